// File: doc/BRIEF.md
# Gold Code Sequence Generator

This block produces a serial spreading code drawn from a Gold family. Two 6-stage maximal-length linear feedback shift registers form the family's base pair. Each register produces its own 63-chip sequence. A code index chosen at load time selects one family member: the first base sequence on its own, the second base sequence on its own, or the XOR of the first with a cyclically advanced copy of the second. Those choices give 65 distinct codes of period 63.

A load strobe captures the code index and reseeds both registers to all-ones. For the XOR codes, the second register is then stepped ahead by the requested chip offset on its own. This is the preload phase, and a busy flag is high throughout it. Once busy is low, the chip output shows the current chip. Each cycle with the enable high moves the output to the next chip. A period-start flag marks the first chip of every 63-chip period counted from the load. Reset behaves like a load of index 0.

Top module: `gold_code_gen`

## Requirements
- R1: After reset, busy is 0, period_start is 1 and chip is 1 (the first chip of the first base sequence, seeded all-ones).
- R2: Code index 0 outputs the sequence u defined by u[t]=1 for t<6 and u[t+6]=u[t+5] XOR u[t]. This sequence has period 63, with 32 ones and 31 zeros per period.
- R3: Code index 1 outputs the sequence v defined by v[t]=1 for t<6 and v[t+6]=v[t+5] XOR v[t+4] XOR v[t+1] XOR v[t]. This sequence has period 63, with 32 ones and 31 zeros per period.
- R4: Code index k, for 2 <= k <= 64, outputs chip t (counted from the first valid chip after load) as u[t] XOR v[(t+k-2) mod 63].
- R5: After a load of index k >= 3, busy is high for exactly k-2 clock cycles. For k <= 2 it does not rise. While busy is high, the chip position does not advance.
- R6: While busy is low and load is low, a low enable leaves chip and period_start unchanged. A high enable advances one chip per cycle.
- R7: period_start is high exactly on chip positions that are multiples of 63 after a load, and only while busy is low.
- R8: A load has priority over enable and over a preload in progress. It restarts seeding, the offset count and the chip position.
- R9: A code index above 64 behaves exactly as index 64.
- R10: Neither shift register ever holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance to the next chip at the clock edge |
| load | input | 1 | Capture code_idx and restart the generator |
| code_idx | input | 7 | Family member to generate (0..64) |
| chip | output | 1 | Current code chip |
| period_start | output | 1 | High on the first chip of each period |
| busy | output | 1 | Preload of the second register in progress |

## Verification
The hardest case to reach is a load that arrives while a long preload is still running. In that case the offset counter, the second register's phase and the chip position must all restart together. The stimulus starts index 64, which has the longest preload of 62 cycles, and issues a second load with a short offset partway through. The bench then checks the new busy length and a full period of chips against the reference model. Indices above the family's range, and enable held low between bursts, are used to confirm that the output continues from the exact chip where it stopped.

// File: rtl/gold_pkg.sv
package gold_pkg;
  typedef enum logic [1:0] {
    MODE_U   = 2'd0,
    MODE_V   = 2'd1,
    MODE_MIX = 2'd2
  } code_mode_e;
endpackage

// File: rtl/gold_lfsr.sv
module gold_lfsr #(
  parameter int         W    = 6,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed,
  input  logic         step,
  output logic [W-1:0] state,
  output logic         serial
);
  logic [W-1:0] state_d;
  logic         fb;

  assign fb = ^(state & TAPS);

  always_comb begin
    state_d = state;
    if (seed)      state_d = '1;
    else if (step) state_d = {fb, state[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '1;
    else        state <= state_d;
  end

  assign serial = state[0];
endmodule

// File: rtl/gold_ctrl.sv
module gold_ctrl
  import gold_pkg::*;
#(
  parameter int W     = 6,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             en,
  input  logic [IDX_W-1:0] code_idx,
  output code_mode_e       mode,
  output logic             seed,
  output logic             step_a,
  output logic             step_b,
  output logic             busy,
  output logic             first
);
  localparam int PERIOD  = (1 << W) - 1;
  localparam int MAX_IDX = PERIOD + 1;

  logic [IDX_W-1:0] idx_sat, off_full;
  logic [W-1:0]     off_in;
  code_mode_e       mode_in, mode_q, mode_d;
  logic [W-1:0]     cnt_q, cnt_d;
  logic [W-1:0]     phase_q, phase_d;

  always_comb begin
    idx_sat  = (code_idx > IDX_W'(MAX_IDX)) ? IDX_W'(MAX_IDX) : code_idx;
    off_full = idx_sat - IDX_W'(2);
    if (idx_sat == '0) begin
      mode_in = MODE_U;
      off_in  = '0;
    end else if (idx_sat == IDX_W'(1)) begin
      mode_in = MODE_V;
      off_in  = '0;
    end else begin
      mode_in = MODE_MIX;
      off_in  = off_full[W-1:0];
    end
  end

  assign busy   = (cnt_q != '0);
  assign seed   = load;
  assign step_a = !load && !busy && en;
  assign step_b = !load && (busy || en);
  assign first  = !busy && (phase_q == '0);

  always_comb begin
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (load) begin
      mode_d  = mode_in;
      cnt_d   = off_in;
      phase_d = '0;
    end else if (busy) begin
      cnt_d = cnt_q - W'(1);
    end else if (en) begin
      phase_d = (phase_q == W'(PERIOD - 1)) ? '0 : phase_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_U;
      cnt_q   <= '0;
      phase_q <= '0;
    end else begin
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/gold_code_gen.sv
module gold_code_gen
  import gold_pkg::*;
#(
  parameter int           W      = 6,
  parameter logic [W-1:0] TAPS_A = 6'b100001,
  parameter logic [W-1:0] TAPS_B = 6'b110011,
  localparam int          IDX_W  = $clog2((1 << W) + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [IDX_W-1:0] code_idx,
  output logic             chip,
  output logic             period_start,
  output logic             busy
);
  code_mode_e   mode;
  logic         seed, step_a, step_b, first;
  logic [W-1:0] a_state, b_state;
  logic         a_bit, b_bit;

  gold_ctrl #(.W(W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .load(load), .en(en), .code_idx(code_idx),
    .mode(mode), .seed(seed), .step_a(step_a), .step_b(step_b),
    .busy(busy), .first(first)
  );

  gold_lfsr #(.W(W), .TAPS(TAPS_A)) u_lfsr_a (
    .clk(clk), .rst_n(rst_n), .seed(seed), .step(step_a),
    .state(a_state), .serial(a_bit)
  );

  gold_lfsr #(.W(W), .TAPS(TAPS_B)) u_lfsr_b (
    .clk(clk), .rst_n(rst_n), .seed(seed), .step(step_b),
    .state(b_state), .serial(b_bit)
  );

  always_comb begin
    case (mode)
      MODE_U:  chip = a_bit;
      MODE_V:  chip = b_bit;
      default: chip = a_bit ^ b_bit;
    endcase
  end

  assign period_start = first;
endmodule

// File: rtl/gold_code_chk.sv
module gold_code_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         load,
  input logic         busy,
  input logic         chip,
  input logic         period_start,
  input logic [W-1:0] a_state,
  input logic [W-1:0] b_state
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !en && !load) |=> ($stable(chip) && $stable(period_start)));

  assert_start_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && en && !load && !busy) |=> !period_start);

  assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !period_start);

  assert_busy_stays_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> !busy);

  assert_reseed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (a_state == '1 && b_state == '1 && period_start == !busy));

  assert_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_state != '0) && (b_state != '0));
endmodule

bind gold_code_gen gold_code_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .load(load), .busy(busy),
  .chip(chip), .period_start(period_start),
  .a_state(a_state), .b_state(b_state)
);

// File: tb/sim_gold_code_gen.sv
module sim_gold_code_gen;
  localparam int N = 63;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [6:0] code_idx = '0;
  logic       chip, period_start, busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_tag = "R4";

  bit u_ref [2*N];
  bit v_ref [2*N];
  logic [1:0] sb_q [$];

  always #2.5 clk = ~clk;

  gold_code_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .code_idx(code_idx),
    .chip(chip), .period_start(period_start), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int eff_off(input int idx);
    int k = (idx > 64) ? 64 : idx;
    return (k >= 2) ? k - 2 : 0;
  endfunction

  function automatic logic exp_chip(input int idx, input int t);
    int k = (idx > 64) ? 64 : idx;
    if (k == 0) return u_ref[t % N];
    if (k == 1) return v_ref[t % N];
    return u_ref[t % N] ^ v_ref[(t + k - 2) % N];
  endfunction

  // monitor: pops one expected chip per consumed chip
  always @(negedge clk) begin
    if (rst_n && en && !busy && !load && sb_q.size() > 0) begin
      logic [1:0] e;
      e = sb_q.pop_front();
      checks++;
      if ({chip, period_start} !== e) begin
        failures++;
        $display("FAIL %s chip/start got=%b exp=%b", cur_tag, {chip, period_start}, e);
      end
    end
  end

  task automatic load_code(input int idx, input string tag);
    int cnt = 0;
    @(posedge clk); #1;
    load = 1'b1; code_idx = 7'(idx); en = 1'b0;
    @(posedge clk); #1;
    load = 1'b0;
    while (busy && cnt < 200) begin
      @(posedge clk); #1;
      cnt++;
    end
    check(cnt == eff_off(idx), tag, cnt, eff_off(idx));
  endtask

  task automatic stream(input int idx, input int t0, input int n, input string tag);
    cur_tag = tag;
    for (int t = t0; t < t0 + n; t++)
      sb_q.push_back({exp_chip(idx, t), ((t % N) == 0) ? 1'b1 : 1'b0});
    en = 1'b1;
    repeat (n) @(posedge clk);
    #1 en = 1'b0;
    check(sb_q.size() == 0, {tag, " queue drained"}, sb_q.size(), 0);
    sb_q.delete();
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // reference sequences
    for (int t = 0; t < 6; t++) begin u_ref[t] = 1; v_ref[t] = 1; end
    for (int t = 0; t + 6 < 2*N; t++) begin
      u_ref[t+6] = u_ref[t+5] ^ u_ref[t];
      v_ref[t+6] = v_ref[t+5] ^ v_ref[t+4] ^ v_ref[t+1] ^ v_ref[t];
    end
    begin
      int ou = 0, ov = 0, pu = 1, pv = 1, zu = 0, zv = 0, ru = 0, rv = 0;
      for (int t = 0; t < N; t++) begin
        ou += u_ref[t]; ov += v_ref[t];
        if (u_ref[t+N] != u_ref[t]) pu = 0;
        if (v_ref[t+N] != v_ref[t]) pv = 0;
        if (t + 6 <= 2*N) begin
          int wu = 0, wv = 0;
          for (int i = 0; i < 6; i++) begin wu += u_ref[t+i]; wv += v_ref[t+i]; end
          if (wu == 0) zu++;
          if (wv == 0) zv++;
          if (wu == 6) ru++;
          if (wv == 6) rv++;
        end
      end
      check(ou == 32, "R2 ones in u", ou, 32);
      check(ov == 32, "R3 ones in v", ov, 32);
      check(pu == 1 && ru == 1, "R2 period 63 of u", ru, 1);
      check(pv == 1 && rv == 1, "R3 period 63 of v", rv, 1);
      check(zu == 0 && zv == 0, "R10 no zero window", zu + zv, 0);
    end

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(period_start == 1, "R1 start after reset", period_start, 1);
    check(chip == 1, "R1 chip after reset", chip, 1);

    // R2: reset state is index 0; stream straight away
    stream(0, 0, 2*N + 4, "R2");
    load_code(1, "R5 idx1");
    stream(1, 0, 2*N + 4, "R3");
    load_code(2, "R5 idx2");
    stream(2, 0, N + 2, "R4 k2");
    load_code(40, "R5 idx40");
    stream(40, 0, 2*N + 2, "R4 k40 R7");

    // R6: hold with enable low, then continue from the same chip
    load_code(17, "R5 idx17");
    stream(17, 0, 20, "R4 k17");
    begin
      logic c0, s0;
      @(negedge clk); c0 = chip; s0 = period_start;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check(chip == c0, "R6 chip held", chip, c0);
      check(period_start == s0, "R6 start held", period_start, s0);
      check(chip == exp_chip(17, 20), "R6 resume chip", chip, exp_chip(17, 20));
    end
    stream(17, 20, N, "R6 resume");

    // R8: load during long preload restarts it
    @(posedge clk); #1 load = 1'b1; code_idx = 7'd64;
    @(posedge clk); #1 load = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(busy == 1, "R8 busy mid preload", busy, 1);
    check(period_start == 0, "R7 no start while busy", period_start, 0);
    load_code(5, "R8 restart busy length");
    stream(5, 0, N + 1, "R8 restart stream");

    // R9: out-of-range index
    load_code(100, "R9 busy length");
    stream(100, 0, N + 1, "R9 idx100 as 64");
    load_code(64, "R5 idx64");
    stream(64, 0, 10, "R4 k64");

    done = 1;
    finish_run();
  end
endmodule